// File: doc/BRIEF.md
# IQ Sample Ingress Buffer

This block takes 32-bit IQ samples from a single antenna-carrier channel and holds them in a small first-in first-out store until a downstream framer reads them. The upstream side qualifies each sample with a valid strobe. The data word that goes with a strobe arrives one clock after the strobe, so the block delays its capture enable by one cycle to pair each strobe with its word.

There are two operating modes, chosen by a mode input. In flow-controlled mode, a ready output throttles the source with a latency of one cycle. Ready falls early enough that the samples already in flight still fit. In resync-armed mode, ready stays low. Samples are ignored until a resync pulse arrives. That pulse empties the store and arms the channel, and from then on every strobe is accepted.

The read side shows the oldest sample split into its I and Q halves, with an empty flag and a read enable. A sticky flag records any sample that was lost because the store was full. The reset input may assert asynchronously. Its release is re-timed inside the block.

Top module: `iq_ingress_buf`

## Requirements
- R1: The read port presents bits [15:0] of a stored input word on `rd_i` and bits [31:16] on `rd_q`.
- R2: When `in_valid` is high in clock cycle t and the sample is accepted, the word stored is the value on `in_data` in cycle t+1, not the value in cycle t.
- R3: In flow-controlled mode (`mode_sync`=0) the store holds 16 words. `in_ready` is high while 13 or fewer words are held and low once 14 or more are held.
- R4: Samples are read back in write order. `rd_empty` is high exactly when no word is held. `rd_en` removes the presented word at the next rising edge, and `rd_en` while empty has no effect.
- R5: In resync-armed mode (`mode_sync`=1) `in_ready` stays low. A valid strobe raised before any resync pulse in that mode is ignored.
- R6: In resync-armed mode a resync pulse empties the store at the closing edge of its cycle. A valid strobe in the same cycle as the resync is accepted. A sample whose valid strobe came in the cycle before the resync is discarded.
- R7: A sample that arrives while 16 words are held and no read occurs is dropped and sets `ovf_flag`. The flag then stays high until reset.
- R8: Asserting `rst_n` low immediately empties the store, clears `ovf_flag` and drops `in_ready`. After `rst_n` rises, the block resumes on the second rising edge.
- R9: Leaving resync-armed mode disarms the channel. After returning to that mode, a new resync pulse is needed before any sample is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low reset; asynchronous assert, release synchronised inside |
| mode_sync | input | 1 | 0 = flow-controlled mode, 1 = resync-armed mode |
| in_valid | input | 1 | Sample strobe; the matching word follows one cycle later |
| in_resync | input | 1 | Resync pulse: flushes and arms in resync-armed mode |
| in_data | input | 32 | Sample word, Q in [31:16], I in [15:0] |
| in_ready | output | 1 | Flow-control indication, ready latency of one cycle |
| rd_en | input | 1 | Remove the presented sample |
| rd_i | output | 16 | I half of the oldest held sample |
| rd_q | output | 16 | Q half of the oldest held sample |
| rd_empty | output | 1 | High when no sample is held |
| ovf_flag | output | 1 | Sticky record of a dropped sample |

## Verification
Errors in the internal state reach the ports quickly.

- **Pointer or count errors.** A wrong write or read pointer shows on `rd_i`/`rd_q` on the first read after the faulty write. A wrong count shows as `in_ready` or `rd_empty` flipping at the wrong occupancy in the same cycle.
- **Capture-delay errors.** A misaligned capture delay stores the neighbouring cycle's word, which becomes visible on the next read.
- **Arming errors.** A stuck arm flag lets samples into an empty store, so `rd_empty` falls one cycle after the stray word.
- **Flush errors.** A missing flush leaves stale words ahead of the fresh one on the read port.

// File: rtl/iq_ingress_pkg.sv
// Shared types for the IQ ingress buffer.
// Assumes a sample word made of two equal-width halves, I in the low half.
package iq_ingress_pkg;
    localparam int IQ_W   = 16;
    localparam int WORD_W = 2 * IQ_W;

    typedef struct packed {
        logic [IQ_W-1:0] q;
        logic [IQ_W-1:0] i;
    } iq_word_t;
endpackage

// File: rtl/iq_rst_sync.sv
// Reset release synchroniser.
// Asserts its output asynchronously with rst_n.
// Releases it only after STAGES rising edges of clk.
// Assumes rst_n is held low for at least one clock cycle.
module iq_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_sync_n
);
    logic [STAGES-1:0] chain_q;

    // Shift ones in after release; clear the whole chain on reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/iq_ingress_ctrl.sv
// Mode and arming control.
// Decides which valid strobes are accepted and delays the capture enable by
// one cycle, so that it lines up with the data word that trails its strobe.
// Also produces the flush request for a resync pulse in resync-armed mode.
// Assumes mode_sync is quasi-static.
module iq_ingress_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_sync,
    input  logic in_valid,
    input  logic in_resync,
    output logic wr_req,
    output logic flush
);
    logic armed_q;
    logic accept;
    logic valid_d_q;

    assign flush = mode_sync & in_resync;

    // A strobe is accepted in flow-controlled mode, or once armed, or with a resync.
    assign accept = mode_sync ? (armed_q | in_resync) : 1'b1;

    // Track arming: cleared outside resync-armed mode, set by a resync pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (!mode_sync) begin
            armed_q <= 1'b0;
        end else if (in_resync) begin
            armed_q <= 1'b1;
        end
    end

    // Delay the accepted strobe by one cycle to meet its data word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_d_q <= 1'b0;
        end else begin
            valid_d_q <= in_valid & accept;
        end
    end

    // A flush in the capture cycle discards the pending word.
    assign wr_req = valid_d_q & ~flush;
endmodule

// File: rtl/iq_sample_fifo.sv
// Sample store with first-word fall-through read.
// Holds DEPTH words. Reports its occupancy, and drops a write that finds it
// full with no read in the same cycle, setting a sticky overflow flag.
// A flush empties it; any read in that cycle is ignored.
module iq_sample_fifo
    import iq_ingress_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_req,
    input  iq_word_t         wr_data,
    input  logic             rd_en,
    output iq_word_t         rd_data,
    output logic             empty,
    output logic [CNT_W-1:0] level,
    output logic             ovf
);
    iq_word_t         mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             full;
    logic             pop;
    logic             push;
    logic             lost;

    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);
    assign pop   = rd_en & ~empty & ~flush;
    assign push  = wr_req & (~full | pop);
    assign lost  = wr_req & full & ~pop;
    assign level = cnt_q;

    // Step a pointer with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store the incoming word at the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[wr_ptr_q] <= wr_data;
        end
    end

    // Maintain pointers and occupancy; flush returns everything to empty.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else if (flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) begin
                wr_ptr_q <= bump(wr_ptr_q);
            end
            if (pop) begin
                rd_ptr_q <= bump(rd_ptr_q);
            end
            if (push && !pop) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (pop && !push) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Record any dropped sample until reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (lost) begin
            ovf <= 1'b1;
        end
    end

    assign rd_data = mem_q[rd_ptr_q];
endmodule

// File: rtl/iq_ingress_buf.sv
// IQ sample ingress buffer, top level.
// Synchronises the reset release, pairs each valid strobe with the word that
// follows it, stores the samples, and drives ready in flow-controlled mode.
// Ready drops when READY_MARGIN or fewer entries are free, which covers the
// one-cycle ready latency plus the one-cycle capture delay.
module iq_ingress_buf
    import iq_ingress_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int READY_MARGIN = 2,
    parameter int SYNC_STAGES  = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sync,
    input  logic              in_valid,
    input  logic              in_resync,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    input  logic              rd_en,
    output logic [IQ_W-1:0]   rd_i,
    output logic [IQ_W-1:0]   rd_q,
    output logic              rd_empty,
    output logic              ovf_flag
);
    logic             rst_sync_n;
    logic             wr_req;
    logic             flush;
    iq_word_t         rd_word;
    logic [CNT_W-1:0] level;

    iq_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_sync_n (rst_sync_n)
    );

    iq_ingress_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_sync_n),
        .mode_sync (mode_sync),
        .in_valid  (in_valid),
        .in_resync (in_resync),
        .wr_req    (wr_req),
        .flush     (flush)
    );

    iq_sample_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .flush   (flush),
        .wr_req  (wr_req),
        .wr_data (iq_word_t'(in_data)),
        .rd_en   (rd_en),
        .rd_data (rd_word),
        .empty   (rd_empty),
        .level   (level),
        .ovf     (ovf_flag)
    );

    // Ready only out of reset, in flow-controlled mode, with spare room.
    assign in_ready = rst_sync_n & ~mode_sync
                    & (level <= CNT_W'(DEPTH - READY_MARGIN - 1));

    assign rd_i = rd_word.i;
    assign rd_q = rd_word.q;
endmodule

// File: rtl/iq_ingress_chk.sv
// Property checker for iq_ingress_buf, attached by bind.
// Watches ports and the capture request that passes between submodules.
module iq_ingress_chk (
    input logic clk,
    input logic rst_sync_n,
    input logic mode_sync,
    input logic in_valid,
    input logic in_resync,
    input logic in_ready,
    input logic rd_empty,
    input logic ovf_flag,
    input logic wr_req
);
    p_capture_delay_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
        wr_req |-> $past(in_valid));

    p_idle_stays_empty_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (rd_empty && !wr_req) |=> rd_empty);

    p_sync_no_ready_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
        mode_sync |-> !in_ready);

    p_resync_flush_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (mode_sync && in_resync) |=> rd_empty);

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
        ovf_flag |=> ovf_flag);
endmodule

bind iq_ingress_buf iq_ingress_chk chk_i (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .mode_sync  (mode_sync),
    .in_valid   (in_valid),
    .in_resync  (in_resync),
    .in_ready   (in_ready),
    .rd_empty   (rd_empty),
    .ovf_flag   (ovf_flag),
    .wr_req     (wr_req)
);

// File: tb/iq_ingress_buf_tb_top.sv
// Self-checking bench for iq_ingress_buf.
module iq_ingress_buf_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_sync = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_resync = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        rd_en = 1'b0;
    logic [15:0] rd_i;
    logic [15:0] rd_q;
    logic        rd_empty;
    logic        ovf_flag;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // Vector table: {input word, expected I, expected Q}.
    localparam logic [63:0] VEC [6] = '{
        {32'h1234_ABCD, 16'hABCD, 16'h1234},
        {32'h0000_FFFF, 16'hFFFF, 16'h0000},
        {32'hFFFF_0000, 16'h0000, 16'hFFFF},
        {32'h8001_7FFE, 16'h7FFE, 16'h8001},
        {32'hDEAD_BEEF, 16'hBEEF, 16'hDEAD},
        {32'h0F0F_F0F0, 16'hF0F0, 16'h0F0F}
    };

    always #10 clk = ~clk;

    iq_ingress_buf dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sync (mode_sync),
        .in_valid  (in_valid),
        .in_resync (in_resync),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .rd_en     (rd_en),
        .rd_i      (rd_i),
        .rd_q      (rd_q),
        .rd_empty  (rd_empty),
        .ovf_flag  (ovf_flag)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_resync = 1'b0;
        rd_en = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        tick();
    endtask

    // One strobe, then its word a cycle later.
    task automatic push_one(input logic [31:0] w);
        in_valid = 1'b1;
        in_data  = 32'hBAD0_BAD0;
        tick();
        in_valid = 1'b0;
        in_data  = w;
        tick();
    endtask

    task automatic pop_one();
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R8: state held during reset.
        check(rd_empty == 1'b1, "R8 empty in reset", 32'(rd_empty), 32'd1);
        check(in_ready == 1'b0, "R8 ready low in reset", 32'(in_ready), 32'd0);
        check(ovf_flag == 1'b0, "R8 ovf clear in reset", 32'(ovf_flag), 32'd0);
        tick();
        rst_n = 1'b1;
        tick();
        check(in_ready == 1'b0, "R8 still held one edge after release", 32'(in_ready), 32'd0);
        tick();
        check(in_ready == 1'b1, "R8 running after second edge", 32'(in_ready), 32'd1);

        // R1 R2 R4: burst from the table, word trails its strobe.
        in_valid = 1'b1;
        in_data  = 32'hBAD0_BAD0;
        tick();
        for (int j = 0; j < 6; j++) begin
            in_data  = VEC[j][63:32];
            in_valid = (j < 5);
            tick();
        end
        in_data = '0;
        for (int j = 0; j < 6; j++) begin
            check(rd_i == VEC[j][31:16], "R1 R4 table I", 32'(rd_i), 32'(VEC[j][31:16]));
            check(rd_q == VEC[j][15:0],  "R1 R4 table Q", 32'(rd_q), 32'(VEC[j][15:0]));
            pop_one();
        end
        check(rd_empty == 1'b1, "R4 empty after drain", 32'(rd_empty), 32'd1);

        // R4: read while empty is ignored.
        pop_one();
        push_one(32'h2222_1111);
        check(rd_i == 16'h1111, "R4 pop on empty ignored", 32'(rd_i), 32'h1111);
        pop_one();

        // R2: the word of the strobe cycle is not the one captured.
        in_valid = 1'b1;
        in_data  = 32'hAAAA_AAAA;
        tick();
        in_valid = 1'b0;
        in_data  = 32'h5555_0101;
        tick();
        check({rd_q, rd_i} == 32'h5555_0101, "R2 trailing word captured",
              {rd_q, rd_i}, 32'h5555_0101);
        pop_one();
        check(rd_empty == 1'b1, "R2 single capture", 32'(rd_empty), 32'd1);

        // R3 R7: fill, ready threshold, overflow.
        for (int k = 0; k < 17; k++) begin
            push_one({16'(k + 16'h0300), 16'(k + 16'h0050)});
            if (k <= 12) check(in_ready == 1'b1, "R3 ready with room", 32'(in_ready), 32'd1);
            if (k >= 13) check(in_ready == 1'b0, "R3 ready low near full", 32'(in_ready), 32'd0);
            if (k == 15) check(ovf_flag == 1'b0, "R7 no ovf at full", 32'(ovf_flag), 32'd0);
        end
        check(ovf_flag == 1'b1, "R7 ovf after extra write", 32'(ovf_flag), 32'd1);
        for (int k = 0; k < 16; k++) begin
            check(rd_i == 16'(k + 16'h0050), "R3 R4 fill order", 32'(rd_i), 32'(k + 16'h0050));
            pop_one();
        end
        check(rd_empty == 1'b1, "R7 extra word dropped", 32'(rd_empty), 32'd1);
        check(ovf_flag == 1'b1, "R7 ovf sticky", 32'(ovf_flag), 32'd1);

        // R8: asynchronous assertion mid cycle.
        push_one(32'h0BAD_0BAD);
        #3 rst_n = 1'b0;
        #1;
        check(rd_empty == 1'b1, "R8 async empty", 32'(rd_empty), 32'd1);
        check(ovf_flag == 1'b0, "R8 async ovf clear", 32'(ovf_flag), 32'd0);
        @(negedge clk);
        do_reset();

        // R5: resync-armed mode, no ready, unarmed strobe ignored.
        mode_sync = 1'b1;
        tick();
        check(in_ready == 1'b0, "R5 ready low in sync mode", 32'(in_ready), 32'd0);
        push_one(32'h7777_7777);
        check(rd_empty == 1'b1, "R5 unarmed strobe ignored", 32'(rd_empty), 32'd1);

        // R6: strobe with resync is accepted.
        in_valid  = 1'b1;
        in_resync = 1'b1;
        tick();
        in_valid  = 1'b0;
        in_resync = 1'b0;
        in_data   = 32'h4444_3333;
        tick();
        check({rd_q, rd_i} == 32'h4444_3333, "R6 strobe with resync",
              {rd_q, rd_i}, 32'h4444_3333);
        push_one(32'h6666_5555);

        // R6: flush, pending word dropped, fresh word kept.
        in_valid = 1'b1;
        tick();
        in_resync = 1'b1;
        in_data   = 32'hDEAD_0001;
        tick();
        in_resync = 1'b0;
        in_valid  = 1'b0;
        in_data   = 32'hCAFE_0002;
        tick();
        check({rd_q, rd_i} == 32'hCAFE_0002, "R6 flush keeps fresh word",
              {rd_q, rd_i}, 32'hCAFE_0002);
        pop_one();
        check(rd_empty == 1'b1, "R6 flush cleared old words", 32'(rd_empty), 32'd1);

        // R9: leaving the mode disarms.
        mode_sync = 1'b0;
        tick();
        mode_sync = 1'b1;
        tick();
        push_one(32'h9999_9999);
        check(rd_empty == 1'b1, "R9 disarmed after mode change", 32'(rd_empty), 32'd1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule